// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from on-chip sources and tells the processor which one to service. It reports the winner as a 4-bit priority level and a fixed event code. Priorities are not stored per source. A priority register holds 4-bit fields, and a compile-time map ties each source to one field. Several sources can therefore share one field as a group, while each keeps its own event code.

A mask register can suppress any source. It is written through two addresses: one address sets the bits written as 1, the other clears them. An external 4-bit level input competes in the same arbitration. A small register port programs the priorities and the mask and reads them back.

Top module: `gpic_top`

## Requirements
- R1: After synchronous reset, `irq_level` and `irq_code` are 0, the priority register is 0, the mask is 0, and `rd_data` is 0.
- R2: A write to address 0 loads the priority register, and a read of address 0 returns it. Field f occupies bits [15-4f:12-4f], so field 0 is the most significant nibble. With the default map, source 0 uses field 0 and source 1 uses field 1. Sources 2 and 3 share field 2, and sources 4 to 7 share field 3.
- R3: Writing to address 1 sets every mask bit whose written bit is 1 and leaves the other mask bits unchanged. Reads of address 1 or address 2 return the mask in the low bits.
- R4: Writing to address 2 clears every mask bit whose written bit is 1 and leaves the other mask bits unchanged.
- R5: A source whose field priority is 0 never wins, and neither does a source whose mask bit is 1.
- R6: Among the eligible requests, the highest priority wins. On a tie between sources, the lower source index wins.
- R7: Source i has event code 0x400 + 0x20*i. External level L (0 to 14) requests at priority 15-L with event code 0x200 + 0x20*L.
- R8: An external level of 0xF means that no external request is present. An external request wins a tie against any source.
- R9: The outputs are registered. They reflect the requests, the external level and the register state present before the clock edge that loads them. When nothing is eligible, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 priority, 1 mask set, 2 mask clear |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for `addr` |
| req | input | 8 | Level-sensitive source requests |
| ext_lvl | input | 4 | External encoded level, 0xF = idle |
| irq_level | output | 4 | Winning priority, 0 = none |
| irq_code | output | 12 | Winning event code, 0 = none |

## Verification
A mask update and a new request can fall in the same cycle. In that case arbitration for that edge still sees the old mask, and the new mask only takes effect one edge later. The bench provokes this by asserting a request on a masked source in the same cycle as a write to the clear address. It expects no winner on the first edge and the source's priority and code on the second edge.

The bench also sweeps all 256 request patterns under several priority settings, masks and external levels. It judges each sweep vector against an arithmetic model of the arbitration.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_MSET = 2'd1,
    SEL_MCLR = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
  import gpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic [REG_W-1:0]   prio_q,
  output logic [NUM_SRC-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(SEL_PRIO);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(SEL_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(SEL_MCLR);

  logic [NUM_SRC-1:0] wr_bits;
  assign wr_bits = wr_data[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      mask_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        if (addr == A_PRIO)      prio_q <= wr_data;
        else if (addr == A_MSET) mask_q <= mask_q | wr_bits;
        else if (addr == A_MCLR) mask_q <= mask_q & ~wr_bits;
      end
      if (addr == A_PRIO)                        rd_data <= prio_q;
      else if (addr == A_MSET || addr == A_MCLR) rd_data <= REG_W'(mask_q);
      else                                       rd_data <= '0;
    end
  end
endmodule

// File: rtl/gpic_ext_map.sv
module gpic_ext_map #(
  parameter int              PRIO_W    = 4,
  parameter int              CODE_W    = 12,
  parameter logic [CODE_W-1:0] EXT_BASE  = 12'h200,
  parameter logic [CODE_W-1:0] CODE_STEP = 12'h020
) (
  input  logic [PRIO_W-1:0] ext_lvl,
  output logic [PRIO_W-1:0] ext_prio,
  output logic [CODE_W-1:0] ext_code
);
  localparam logic [PRIO_W-1:0] IDLE_LVL = '1;

  always_comb begin
    if (ext_lvl == IDLE_LVL) begin
      ext_prio = '0;
      ext_code = '0;
    end else begin
      ext_prio = IDLE_LVL - ext_lvl;
      ext_code = EXT_BASE + CODE_W'(ext_lvl) * CODE_STEP;
    end
  end
endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter #(
  parameter int                      NUM_SRC    = 8,
  parameter int                      NUM_FIELDS = 4,
  parameter int                      PRIO_W     = 4,
  parameter int                      CODE_W     = 12,
  parameter int                      IDX_W      = 2,
  parameter logic [NUM_SRC*IDX_W-1:0] FIELD_MAP = 16'b11_11_11_11_10_10_01_00,
  parameter logic [CODE_W-1:0]       SRC_BASE   = 12'h400,
  parameter logic [CODE_W-1:0]       CODE_STEP  = 12'h020
) (
  input  logic [NUM_SRC-1:0]           req,
  input  logic [NUM_SRC-1:0]           mask,
  input  logic [NUM_FIELDS*PRIO_W-1:0] prio_reg,
  input  logic [PRIO_W-1:0]            ext_prio,
  input  logic [CODE_W-1:0]            ext_code,
  output logic [PRIO_W-1:0]            win_prio,
  output logic [CODE_W-1:0]            win_code
);
  localparam int REG_W = NUM_FIELDS * PRIO_W;

  logic [PRIO_W-1:0] eff_prio [NUM_SRC];
  logic [CODE_W-1:0] src_code [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int FLD = int'(FIELD_MAP[i*IDX_W +: IDX_W]);
    localparam int MSB = REG_W - 1 - PRIO_W * FLD;
    assign eff_prio[i] = (req[i] && !mask[i]) ? prio_reg[MSB -: PRIO_W] : '0;
    assign src_code[i] = SRC_BASE + CODE_W'(i) * CODE_STEP;
  end

  // External candidate seeds the search; sources replace only on strictly higher.
  always_comb begin
    win_prio = ext_prio;
    win_code = ext_code;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eff_prio[i] > win_prio) begin
        win_prio = eff_prio[i];
        win_code = src_code[i];
      end
    end
  end
endmodule

// File: rtl/gpic_top.sv
module gpic_top #(
  parameter int                      NUM_SRC    = 8,
  parameter int                      NUM_FIELDS = 4,
  parameter int                      PRIO_W     = 4,
  parameter int                      CODE_W     = 12,
  parameter int                      ADDR_W     = 2,
  parameter logic [NUM_SRC*$clog2(NUM_FIELDS)-1:0] FIELD_MAP = 16'b11_11_11_11_10_10_01_00,
  parameter logic [CODE_W-1:0]       SRC_BASE   = 12'h400,
  parameter logic [CODE_W-1:0]       EXT_BASE   = 12'h200,
  parameter logic [CODE_W-1:0]       CODE_STEP  = 12'h020
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_FIELDS*PRIO_W-1:0]  wr_data,
  output logic [NUM_FIELDS*PRIO_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0]            req,
  input  logic [PRIO_W-1:0]             ext_lvl,
  output logic [PRIO_W-1:0]             irq_level,
  output logic [CODE_W-1:0]             irq_code
);
  localparam int REG_W = NUM_FIELDS * PRIO_W;
  localparam int IDX_W = $clog2(NUM_FIELDS);

  logic [REG_W-1:0]   prio_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [PRIO_W-1:0]  ext_prio, win_prio;
  logic [CODE_W-1:0]  ext_code, win_code;

  gpic_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .prio_q(prio_q), .mask_q(mask_q)
  );

  gpic_ext_map #(.PRIO_W(PRIO_W), .CODE_W(CODE_W), .EXT_BASE(EXT_BASE),
                 .CODE_STEP(CODE_STEP)) u_ext (
    .ext_lvl(ext_lvl), .ext_prio(ext_prio), .ext_code(ext_code)
  );

  gpic_arbiter #(.NUM_SRC(NUM_SRC), .NUM_FIELDS(NUM_FIELDS), .PRIO_W(PRIO_W),
                 .CODE_W(CODE_W), .IDX_W(IDX_W), .FIELD_MAP(FIELD_MAP),
                 .SRC_BASE(SRC_BASE), .CODE_STEP(CODE_STEP)) u_arb (
    .req(req), .mask(mask_q), .prio_reg(prio_q), .ext_prio(ext_prio),
    .ext_code(ext_code), .win_prio(win_prio), .win_code(win_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_level <= win_prio;
      irq_code  <= (win_prio == '0) ? '0 : win_code;
    end
  end
endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16,
  parameter int PRIO_W  = 4,
  parameter int CODE_W  = 12,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wr_data,
  input logic [NUM_SRC-1:0] req,
  input logic [PRIO_W-1:0]  ext_lvl,
  input logic [PRIO_W-1:0]  irq_level,
  input logic [CODE_W-1:0]  irq_code,
  input logic [REG_W-1:0]   prio_q,
  input logic [NUM_SRC-1:0] mask_q
);
  // R2
  prio_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0)) |=> prio_q == $past(wr_data));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(1)) |=>
      ((mask_q & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0])));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2)) |=> ((mask_q & $past(wr_data[NUM_SRC-1:0])) == '0));

  // R7
  code_step_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (irq_code[4:0] == 5'd0 && irq_code != '0));

  // R8
  ext_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_lvl == '0) |=> (irq_level == '1 && irq_code == CODE_W'(12'h200)));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && ext_lvl == '1) |=> (irq_level == '0 && irq_code == '0));
endmodule

bind gpic_top gpic_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(NUM_FIELDS*PRIO_W), .PRIO_W(PRIO_W),
  .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .req(req), .ext_lvl(ext_lvl), .irq_level(irq_level), .irq_code(irq_code),
  .prio_q(prio_q), .mask_q(mask_q)
);

// File: tb/tb_gpic_top.sv
module tb_gpic_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [7:0]  req;
  logic [3:0]  ext_lvl;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpic_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .req(req), .ext_lvl(ext_lvl),
    .irq_level(irq_level), .irq_code(irq_code)
  );

  function automatic logic [15:0] model(input logic [7:0] rq, input logic [3:0] ex,
                                        input logic [15:0] pr, input logic [7:0] mk);
    int bl = 0;
    int bc = 0;
    if (ex != 4'hF) begin
      bl = 15 - int'(ex);
      bc = 'h200 + 'h20 * int'(ex);
    end
    for (int i = 0; i < 8; i++) begin
      int f;
      int p;
      f = (i < 2) ? i : ((i < 4) ? 2 : 3);
      p = int'((pr >> (12 - 4 * f)) & 16'hF);
      if (rq[i] && !mk[i] && p > bl) begin
        bl = p;
        bc = 'h400 + 'h20 * i;
      end
    end
    return {bl[3:0], bc[11:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic apply(input string tag, input logic [7:0] rq, input logic [3:0] ex,
                       input logic [15:0] pr, input logic [7:0] mk);
    logic [15:0] e;
    @(negedge clk);
    req = rq; ext_lvl = ex;
    @(negedge clk);
    e = model(rq, ex, pr, mk);
    check(tag, {16'd0, irq_level, irq_code}, {16'd0, e});
  endtask

  initial begin
    logic [15:0] rv;
    logic [15:0] prios [5] = '{16'h0000, 16'h5555, 16'h1234, 16'hF3A7, 16'h9C1E};
    logic [7:0]  masks [3] = '{8'h00, 8'hA5, 8'hFF};
    logic [3:0]  exts  [4] = '{4'h0, 4'h5, 4'hE, 4'hF};
    rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wr_data = '0; req = '0; ext_lvl = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 level", {28'd0, irq_level}, 32'd0);
    check("R1 code", {20'd0, irq_code}, 32'd0);
    reg_rd(2'd0, rv); check("R1 prio", {16'd0, rv}, 32'd0);
    reg_rd(2'd1, rv); check("R1 mask", {16'd0, rv}, 32'd0);

    // R2 priority readback and field position
    reg_wr(2'd0, 16'hA3C5);
    reg_rd(2'd0, rv); check("R2 readback", {16'd0, rv}, 32'h0000A3C5);
    apply("R2 field0 src0", 8'h01, 4'hF, 16'hA3C5, 8'h00);
    apply("R2 group src5", 8'h20, 4'hF, 16'hA3C5, 8'h00);
    apply("R2 group src3", 8'h08, 4'hF, 16'hA3C5, 8'h00);

    // R3 / R4 mask set and clear
    reg_wr(2'd1, 16'h0011);
    reg_wr(2'd1, 16'h0030);
    reg_rd(2'd1, rv); check("R3 set", {16'd0, rv}, 32'h00000031);
    reg_wr(2'd2, 16'h0021);
    reg_rd(2'd2, rv); check("R4 clear", {16'd0, rv}, 32'h00000010);
    reg_wr(2'd2, 16'h00FF);
    reg_rd(2'd1, rv); check("R4 clear all", {16'd0, rv}, 32'h00000000);

    // R5 masked source ignored, zero-priority ignored
    reg_wr(2'd1, 16'h0001);
    apply("R5 masked", 8'h01, 4'hF, 16'hA3C5, 8'h01);
    reg_wr(2'd0, 16'h0F00);
    apply("R5 zero prio", 8'h01, 4'hF, 16'h0F00, 8'h01);
    // R8 tie: external level 0 vs none
    apply("R8 ext tie", 8'h04, 4'h0, 16'h0F00, 8'h01);

    // Same-cycle mask clear and request
    reg_wr(2'd0, 16'h7000);
    @(negedge clk);
    req = 8'h01; ext_lvl = 4'hF; wr_en = 1'b1; addr = 2'd2; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 old mask edge", {20'd0, irq_level, irq_code}, 32'd0);
    @(negedge clk);
    check("R9 new mask edge", {20'd0, irq_level, irq_code}, {16'd0, 4'h7, 12'h400});

    // R6 / R7 / R8 sweep
    foreach (prios[p]) begin
      reg_wr(2'd0, prios[p]);
      foreach (masks[m]) begin
        reg_wr(2'd2, 16'h00FF);
        reg_wr(2'd1, {8'd0, masks[m]});
        foreach (exts[x]) begin
          for (int r = 0; r < 256; r++) begin
            apply("R6 R7 R8 sweep", 8'(r), exts[x], prios[p], masks[m]);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule